// File: doc/BRIEF.md
# SDRAM Write Burst Capture Unit

This block is the device-side write path of a single data rate synchronous DRAM. It receives an already decoded command (no-op, write, precharge), a bank and column address, an auto-precharge flag, a data word and a per-byte mask. It stores burst data into a small internal word array. The first word of a burst is captured on the same clock edge as the WRITE command, with no prefetch. The remaining words follow on each later edge, at columns produced by a burst column stepper.

The burst length is a static input. It selects one beat, two, four or eight beats, or an unbounded full-page burst that wraps around the page. A newer WRITE takes over the write port at once and cuts off any burst in flight. A PRECHARGE command ends a running burst. When a burst that carries the auto-precharge flag runs to its natural end, the block emits a one-cycle request naming the bank to close. A combinational lookup port returns any stored word, so the array contents can be observed from outside.

Top module: `sdram_wr_capture`

## Requirements
- R1: On a cycle where `cmd` is WRITE (2'b01), `wr_active` is high and the word on `din` is stored at the bank and column given with that command, on that same rising edge.
- R2: `burst_len` selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives full page, and any other code gives 1. For fixed lengths, later beats are stored on each successive edge at columns that count up through the low column bits and wrap within the aligned block of the burst length. For example, length 4 starting at column 6 writes columns 6, 7, 4, 5.
- R3: Once a fixed-length burst has delivered its last beat, and while no new WRITE arrives, `wr_active` stays low and the data on `din` changes no stored word.
- R4: In full-page mode the burst has no beat limit. After the last column of the page the column counter returns to column 0 and writing continues.
- R5: A WRITE is accepted on every clock, with no gap cycles, to any bank and column. The data presented with the new command is stored at the new address, and the older burst stops at once.
- R6: `dmask[i]` high blocks byte lane i (bits 8i+7 down to 8i) of that beat only. The other lanes of that beat, and the other beats, are written normally.
- R7: When a burst with the auto-precharge flag set delivers its final beat, `pre_req` is high for exactly the following cycle, with `pre_bank` naming that burst's bank. A burst cut short by a newer WRITE produces no such pulse, and neither does a burst whose flag is clear.
- R8: A PRECHARGE command (2'b10) ends a running burst, fixed or full page. Data on that cycle and on all later cycles until the next WRITE is ignored, and no `pre_req` pulse is produced. Codes 2'b00 and 2'b11 act as no-op.
- R9: While `rst` is high, and after it is released, every stored word reads as zero and `wr_active` and `pre_req` are low.
- R10: `rd_data` returns, in the same cycle, the word stored at `rd_bank`/`rd_col`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Decoded command: 00 no-op, 01 WRITE, 10 PRECHARGE, 11 no-op |
| bank | input | BANK_BITS (1) | Bank address sampled with WRITE |
| col | input | COL_BITS (4) | Start column sampled with WRITE |
| auto_pre | input | 1 | Auto-precharge flag sampled with WRITE |
| burst_len | input | 3 | Static burst length code |
| din | input | DATA_W (32) | Write data, one word per beat |
| dmask | input | DATA_W/8 (4) | Per-byte write block, high blocks the lane |
| wr_active | output | 1 | High on each cycle whose `din` word will be stored |
| pre_req | output | 1 | One-cycle auto-precharge request |
| pre_bank | output | BANK_BITS (1) | Bank named by `pre_req` |
| rd_bank | input | BANK_BITS (1) | Lookup bank |
| rd_col | input | COL_BITS (4) | Lookup column |
| rd_data | output | DATA_W (32) | Stored word at the lookup address |

## Verification
The bound checker watches, on every cycle, the command-level rules: a WRITE always opens a write beat, an idle block stays idle until a WRITE arrives, a PRECHARGE leaves the next non-write cycle without a beat, and a precharge pulse only ever follows a cycle that stored a word. The exact column sequence of each burst length, the wrap of full-page bursts past the page end, truncation by a newer WRITE, byte masking and the contents of the array can only be shown by the directed scenarios. These scenarios compare every stored word against the bench's own model through the lookup port.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

    typedef enum logic [1:0] {
        CMD_NOP       = 2'b00,
        CMD_WRITE     = 2'b01,
        CMD_PRECHARGE = 2'b10,
        CMD_RSVD      = 2'b11
    } cmd_e;

    localparam logic [2:0] BLEN_1    = 3'd0;
    localparam logic [2:0] BLEN_2    = 3'd1;
    localparam logic [2:0] BLEN_4    = 3'd2;
    localparam logic [2:0] BLEN_8    = 3'd3;
    localparam logic [2:0] BLEN_PAGE = 3'd7;

    // Beats in a fixed burst; zero marks the unbounded page mode.
    function automatic logic [3:0] blen_span(input logic [2:0] code);
        case (code)
            BLEN_2:    return 4'd2;
            BLEN_4:    return 4'd4;
            BLEN_8:    return 4'd8;
            BLEN_PAGE: return 4'd0;
            default:   return 4'd1;
        endcase
    endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import sdram_wr_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int NUM_COLS  = 16,
    localparam int BW = $clog2(NUM_BANKS),
    localparam int CW = $clog2(NUM_COLS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cmd,
    input  logic [BW-1:0] cmd_bank,
    input  logic [CW-1:0] cmd_col,
    input  logic          cmd_ap,
    input  logic [2:0]    bl_code,
    output logic          we,
    output logic [BW-1:0] we_bank,
    output logic [CW-1:0] we_col,
    output logic          pre_req,
    output logic [BW-1:0] pre_bank
);

    typedef struct packed {
        logic          busy;
        logic          page;
        logic          ap;
        logic [BW-1:0] bank;
        logic [CW-1:0] col;
        logic [CW-1:0] wrap;
        logic [3:0]    left;
    } burst_t;

    burst_t        cur, nxt;
    logic          pre_n;
    logic [BW-1:0] preb_n;
    logic [3:0]    span;
    logic          is_wr, is_pre;

    function automatic logic [CW-1:0] step_col(input logic [CW-1:0] c,
                                               input logic [CW-1:0] w);
        logic [CW-1:0] inc;
        inc = c + 1'b1;
        return (c & ~w) | (inc & w);
    endfunction

    assign is_wr  = (cmd == CMD_WRITE);
    assign is_pre = (cmd == CMD_PRECHARGE);
    assign span   = blen_span(bl_code);

    always_comb begin
        nxt     = cur;
        pre_n   = 1'b0;
        preb_n  = pre_bank;
        we      = 1'b0;
        we_bank = cur.bank;
        we_col  = cur.col;
        if (is_wr) begin
            we        = 1'b1;
            we_bank   = cmd_bank;
            we_col    = cmd_col;
            nxt.page  = (span == 4'd0);
            nxt.wrap  = (span == 4'd0) ? '1 : CW'(span - 4'd1);
            nxt.bank  = cmd_bank;
            nxt.ap    = cmd_ap;
            nxt.col   = step_col(cmd_col, nxt.wrap);
            nxt.left  = (span == 4'd0) ? 4'd0 : span - 4'd1;
            nxt.busy  = (span == 4'd0) || (span > 4'd1);
            if (!nxt.busy && cmd_ap) begin
                pre_n  = 1'b1;
                preb_n = cmd_bank;
            end
        end else if (cur.busy && is_pre) begin
            nxt.busy = 1'b0;
        end else if (cur.busy) begin
            we      = 1'b1;
            nxt.col = step_col(cur.col, cur.wrap);
            if (!cur.page) begin
                nxt.left = cur.left - 4'd1;
                if (cur.left == 4'd1) begin
                    nxt.busy = 1'b0;
                    if (cur.ap) begin
                        pre_n  = 1'b1;
                        preb_n = cur.bank;
                    end
                end
            end
        end
        if (rst) we = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= '0;
            pre_req  <= 1'b0;
            pre_bank <= '0;
        end else begin
            cur      <= nxt;
            pre_req  <= pre_n;
            pre_bank <= preb_n;
        end
    end

endmodule

// File: rtl/word_array.sv
module word_array #(
    parameter int NUM_BANKS = 2,
    parameter int NUM_COLS  = 16,
    parameter int DATA_W    = 32,
    localparam int BW    = $clog2(NUM_BANKS),
    localparam int CW    = $clog2(NUM_COLS),
    localparam int LANES = DATA_W / 8,
    localparam int DEPTH = NUM_BANKS * NUM_COLS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [BW-1:0]     wr_bank,
    input  logic [CW-1:0]     wr_col,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_mask,
    input  logic [BW-1:0]     rd_bank,
    input  logic [CW-1:0]     rd_col,
    output logic [DATA_W-1:0] rd_data
);

    logic [BW+CW-1:0] wr_idx, rd_idx;
    assign wr_idx = {wr_bank, wr_col};
    assign rd_idx = {rd_bank, rd_col};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) lane_mem[i] <= '0;
            end else if (we && !wr_mask[l]) begin
                lane_mem[wr_idx] <= wr_data[8*l +: 8];
            end
        end

        assign rd_data[8*l +: 8] = lane_mem[rd_idx];
    end

endmodule

// File: rtl/sdram_wr_capture.sv
module sdram_wr_capture
    import sdram_wr_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int NUM_COLS  = 16,
    parameter int DATA_W    = 32,
    localparam int BANK_BITS = $clog2(NUM_BANKS),
    localparam int COL_BITS  = $clog2(NUM_COLS),
    localparam int LANES     = DATA_W / 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           cmd,
    input  logic [BANK_BITS-1:0] bank,
    input  logic [COL_BITS-1:0]  col,
    input  logic                 auto_pre,
    input  logic [2:0]           burst_len,
    input  logic [DATA_W-1:0]    din,
    input  logic [LANES-1:0]     dmask,
    output logic                 wr_active,
    output logic                 pre_req,
    output logic [BANK_BITS-1:0] pre_bank,
    input  logic [BANK_BITS-1:0] rd_bank,
    input  logic [COL_BITS-1:0]  rd_col,
    output logic [DATA_W-1:0]    rd_data
);

    logic                 we;
    logic [BANK_BITS-1:0] we_bank;
    logic [COL_BITS-1:0]  we_col;

    burst_ctrl #(
        .NUM_BANKS(NUM_BANKS),
        .NUM_COLS (NUM_COLS)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .cmd_bank(bank),
        .cmd_col (col),
        .cmd_ap  (auto_pre),
        .bl_code (burst_len),
        .we      (we),
        .we_bank (we_bank),
        .we_col  (we_col),
        .pre_req (pre_req),
        .pre_bank(pre_bank)
    );

    word_array #(
        .NUM_BANKS(NUM_BANKS),
        .NUM_COLS (NUM_COLS),
        .DATA_W   (DATA_W)
    ) u_array (
        .clk    (clk),
        .rst    (rst),
        .we     (we),
        .wr_bank(we_bank),
        .wr_col (we_col),
        .wr_data(din),
        .wr_mask(dmask),
        .rd_bank(rd_bank),
        .rd_col (rd_col),
        .rd_data(rd_data)
    );

    assign wr_active = we;

endmodule

// File: rtl/wr_capture_checker.sv
module wr_capture_checker
    import sdram_wr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] cmd,
    input logic       wr_active,
    input logic       pre_req
);

    // R1: a WRITE always opens a beat in its own cycle
    a_r1_write_beat: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_WRITE) |-> wr_active);

    // R3: an idle block stays idle until a WRITE arrives
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_active) && cmd != CMD_WRITE) |-> !wr_active);

    // R8: after a PRECHARGE, no beat until a new WRITE
    a_r8_precharge_stops: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd == CMD_PRECHARGE) && cmd != CMD_WRITE) |-> !wr_active);

    // R7: a precharge request only follows a cycle that stored a word
    a_r7_pulse_after_beat: assert property (@(posedge clk) disable iff (rst)
        pre_req |-> $past(wr_active));

    // R8: a PRECHARGE cycle never yields a request
    a_r8_no_pulse_on_precharge: assert property (@(posedge clk) disable iff (rst)
        $past(cmd == CMD_PRECHARGE) |-> !pre_req);

    // R9: nothing is written while reset is applied
    a_r9_reset_quiet: assert property (@(posedge clk)
        rst |-> !wr_active);

endmodule

bind sdram_wr_capture wr_capture_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .wr_active(wr_active),
    .pre_req  (pre_req)
);

// File: tb/test_sdram_wr_capture.sv
module test_sdram_wr_capture;
    import sdram_wr_pkg::*;

    localparam int NB = 2;
    localparam int NC = 16;
    localparam int DW = 32;
    localparam int BW = 1;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cmd = 2'b00;
    logic [BW-1:0] bank = '0;
    logic [CW-1:0] col = '0;
    logic          auto_pre = 1'b0;
    logic [2:0]    burst_len = 3'd0;
    logic [DW-1:0] din = '0;
    logic [3:0]    dmask = '0;
    logic          wr_active, pre_req;
    logic [BW-1:0] pre_bank;
    logic [BW-1:0] rd_bank = '0;
    logic [CW-1:0] rd_col = '0;
    logic [DW-1:0] rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [DW-1:0] model [NB][NC];

    always #10 clk = ~clk;

    sdram_wr_capture i_sdram_wr_capture (
        .clk(clk), .rst(rst), .cmd(cmd), .bank(bank), .col(col),
        .auto_pre(auto_pre), .burst_len(burst_len), .din(din), .dmask(dmask),
        .wr_active(wr_active), .pre_req(pre_req), .pre_bank(pre_bank),
        .rd_bank(rd_bank), .rd_col(rd_col), .rd_data(rd_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int nxt_col(input int c, input int span);
        int w;
        w = (span == 0) ? NC - 1 : span - 1;
        return (c & ~w) | ((c + 1) & w);
    endfunction

    // One clock: drive, check the beat flag, apply to model, check the pulse.
    task automatic step(input logic [1:0] c, input int b, input int cl, input bit ap,
                        input logic [31:0] d, input logic [3:0] m,
                        input bit ea, input int eb, input int ec,
                        input bit ep, input int epb, input string req);
        @(negedge clk);
        cmd = c; bank = BW'(b); col = CW'(cl); auto_pre = ap; din = d; dmask = m;
        #2;
        chk(req, "wr_active", 32'(wr_active), 32'(ea));
        @(posedge clk);
        if (ea)
            for (int l = 0; l < 4; l++)
                if (!m[l]) model[eb][ec][8*l +: 8] = d[8*l +: 8];
        #1;
        chk(req, "pre_req", 32'(pre_req), 32'(ep));
        if (ep) chk(req, "pre_bank", 32'(pre_bank), 32'(epb));
    endtask

    task automatic check_array(input string req);
        int nbad;
        nbad = 0;
        @(negedge clk);
        cmd = CMD_NOP;
        for (int b = 0; b < NB; b++)
            for (int c = 0; c < NC; c++) begin
                rd_bank = BW'(b); rd_col = CW'(c);
                #1;
                if (rd_data !== model[b][c]) begin
                    nbad++;
                    $display("FAIL %s array[%0d][%0d] actual=%0h expected=%0h",
                             req, b, c, rd_data, model[b][c]);
                end
            end
        total++;
        if (nbad != 0) bad++;
    endtask

    // Full burst: WRITE then NOPs, every beat expected active.
    task automatic burst(input int b, input int c, input bit ap, input int span,
                         input int beats, input logic [31:0] seed, input string req);
        int cc;
        cc = c;
        for (int i = 0; i < beats; i++) begin
            step(i == 0 ? CMD_WRITE : CMD_NOP, b, c, ap, seed + i, 4'b0000,
                 1'b1, b, cc, (ap && span != 0 && i == span - 1), b, req);
            cc = nxt_col(cc, span);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R9", "wr_active in reset", 32'(wr_active), 0);
        chk("R9", "pre_req in reset", 32'(pre_req), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9", "wr_active after reset", 32'(wr_active), 0);
        check_array("R9 R10");
    endtask

    task automatic t_bl4();
        burst_len = BLEN_4;
        burst(1, 6, 1'b0, 4, 4, 32'hA4000000, "R2");
        step(CMD_NOP, 1, 0, 0, 32'hDEAD0001, 4'b0000, 1'b0, 0, 0, 1'b0, 0, "R3");
        step(CMD_NOP, 1, 0, 0, 32'hDEAD0002, 4'b0000, 1'b0, 0, 0, 1'b0, 0, "R3");
        check_array("R2 R3");
    endtask

    task automatic t_bl8_ap();
        burst_len = BLEN_8;
        burst(1, 13, 1'b1, 8, 8, 32'hB8000000, "R7");
        step(CMD_NOP, 0, 0, 0, 32'hDEAD0003, 4'b0000, 1'b0, 0, 0, 1'b0, 0, "R7");
        check_array("R2 R7");
    endtask

    task automatic t_bl1();
        burst_len = BLEN_1;
        step(CMD_WRITE, 0, 3, 0, 32'hC1000001, 4'b0000, 1'b1, 0, 3, 1'b0, 0, "R1");
        step(CMD_NOP, 0, 0, 0, 32'hDEAD0004, 4'b0000, 1'b0, 0, 0, 1'b0, 0, "R3");
        step(CMD_WRITE, 1, 15, 1, 32'hC1000002, 4'b0000, 1'b1, 1, 15, 1'b1, 1, "R7");
        step(CMD_NOP, 0, 0, 0, 32'hDEAD0005, 4'b0000, 1'b0, 0, 0, 1'b0, 0, "R3");
        check_array("R1 R3");
    endtask

    task automatic t_page();
        burst_len = BLEN_PAGE;
        burst(1, 14, 1'b1, 0, 20, 32'hD0000000, "R4");
        step(CMD_PRECHARGE, 0, 0, 0, 32'hDEAD0006, 4'b0000, 1'b0, 0, 0, 1'b0, 0, "R8");
        step(CMD_NOP, 0, 0, 0, 32'hDEAD0007, 4'b0000, 1'b0, 0, 0, 1'b0, 0, "R8");
        check_array("R4 R8");
    endtask

    task automatic t_trunc();
        burst_len = BLEN_8;
        step(CMD_WRITE, 0, 0, 1, 32'hE0000000, 4'b0000, 1'b1, 0, 0, 1'b0, 0, "R5");
        step(CMD_NOP, 0, 0, 0, 32'hE0000001, 4'b0000, 1'b1, 0, 1, 1'b0, 0, "R5");
        step(CMD_NOP, 0, 0, 0, 32'hE0000002, 4'b0000, 1'b1, 0, 2, 1'b0, 0, "R5");
        step(CMD_WRITE, 1, 5, 0, 32'hE0000003, 4'b0000, 1'b1, 1, 5, 1'b0, 0, "R5");
        step(CMD_WRITE, 0, 12, 0, 32'hE0000004, 4'b0000, 1'b1, 0, 12, 1'b0, 0, "R5");
        burst(1, 3, 1'b1, 8, 8, 32'hE1000000, "R5");
        step(CMD_NOP, 0, 0, 0, 32'hDEAD0008, 4'b0000, 1'b0, 0, 0, 1'b0, 0, "R5");
        check_array("R5");
    endtask

    task automatic t_mask();
        burst_len = BLEN_2;
        step(CMD_WRITE, 0, 1, 0, 32'h11223344, 4'b0101, 1'b1, 0, 1, 1'b0, 0, "R6");
        step(CMD_NOP, 0, 0, 0, 32'h55667788, 4'b1010, 1'b1, 0, 0, 1'b0, 0, "R6");
        step(CMD_NOP, 0, 0, 0, 32'hDEAD0009, 4'b0000, 1'b0, 0, 0, 1'b0, 0, "R6");
        check_array("R6");
    endtask

    initial begin
        for (int b = 0; b < NB; b++)
            for (int c = 0; c < NC; c++) model[b][c] = '0;
        repeat (3) @(posedge clk);
        t_reset();
        t_bl4();
        t_bl8_ap();
        t_bl1();
        t_page();
        t_trunc();
        t_mask();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule